// File: doc/BRIEF.md
# Axis Threshold Motion Wake-Up Detector

This block watches signed three-axis acceleration samples and raises a wake-up event when the device starts to move. A sample strobe loads the latest X, Y and Z values into a holding stage. A divider running on the base clock makes an evaluation tick at one of eight slow rates. On each tick, each of the six directions (X+, X-, Y+, Y-, Z+, Z-) is compared against a programmable threshold, and only the directions whose enable bit is set take part.

A debounce counter counts ticks on which at least one enabled direction qualifies. Any tick with no qualifying direction clears the counter. When the count reaches the programmed delay, the block pulses `wake_o` for one clock. It also latches the set of directions that qualified on that tick onto `wake_dir_o`. The detector then stays quiet until a release pulse clears the direction vector and re-arms it.

The threshold uses the same scale as the 8-bit samples, 16 counts per g. The threshold input is an unsigned magnitude, so the default of 8 means 0.5 g.

Top module: `motion_wake_det`

## Requirements
- R1: After reset, `wake_o` is 0 and `wake_dir_o` is 6'b000000.
- R2: A positive direction qualifies only when the held sample is strictly greater than +threshold; a sample equal to the threshold does not qualify.
- R3: A negative direction qualifies only when the held sample is strictly less than -threshold. The compare is signed and uses sign-extended operands.
- R4: Direction bits are ordered [0]=Z+, [1]=Z-, [2]=Y+, [3]=Y-, [4]=X+, [5]=X-, in both `dir_en_i` and `wake_dir_o`. A direction whose enable bit is 0 can neither cause an event nor appear in `wake_dir_o`.
- R5: An event fires on the Nth consecutive qualifying tick, where N is `delay_i`. A delay of 0 behaves as 1.
- R6: A tick on which no enabled direction qualifies resets the consecutive count to zero.
- R7: With `enable_i` held high from a disabled state, evaluation ticks occur every FAST_DIV*2^(7-`rate_sel_i`) clocks. The first tick comes that many clocks after enable rises. The default FAST_DIV is 4, so code 7 gives 4 clocks and code 0 gives 512 clocks.
- R8: `wake_o` is a single-clock pulse. At that pulse, `wake_dir_o` holds the nonzero set of enabled directions that qualified on the firing tick.
- R9: After an event, no further event occurs and `wake_dir_o` holds its value until `release_i` is pulsed. A release clears `wake_dir_o` to zero and re-arms the detector.
- R10: While `enable_i` is 0, no event occurs and the consecutive count and rate divider are cleared.
- R11: Sample inputs are captured only in a cycle where `smp_valid_i` is 1. Changing them without the strobe has no effect on detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Detector enable |
| rate_sel_i | input | 3 | Evaluation rate code, 7 fastest |
| thr_i | input | 8 | Threshold magnitude, 16 counts per g |
| delay_i | input | 8 | Consecutive qualifying ticks required (0 acts as 1) |
| dir_en_i | input | 6 | Per-direction enable mask |
| smp_valid_i | input | 1 | Sample strobe |
| smp_x_i | input | 8 | X sample, two's complement |
| smp_y_i | input | 8 | Y sample, two's complement |
| smp_z_i | input | 8 | Z sample, two's complement |
| release_i | input | 1 | Clears the direction vector and re-arms the detector |
| wake_o | output | 1 | One-clock wake-up event |
| wake_dir_o | output | 6 | Directions that qualified on the firing tick |

## Verification
The bench places samples exactly at the threshold on both signs. A design that used a non-strict or unsigned compare would fire on them. It breaks a qualifying run with one quiet tick, and also interrupts a run by briefly dropping the enable. A design that kept its count across either break would fire ticks early. It counts clocks from enable to event at three rate codes, which exposes an off-by-one divider or a wrong shift direction. It also holds a qualifying sample after an event without a release, disables the moving axis, and changes sample inputs without a strobe. Each of these stimuli must leave the outputs untouched.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned NUM_AXES = 3;
  localparam int unsigned NUM_DIRS = 2 * NUM_AXES;
  localparam int unsigned RATE_W   = 3;
  localparam int unsigned RATE_MAX = (1 << RATE_W) - 1;

  typedef logic [NUM_DIRS-1:0] dir_vec_t;

  // bit index of a direction: axis 0 = Z, 1 = Y, 2 = X; even = positive
  function automatic int unsigned dir_pos_bit(input int unsigned axis);
    return 2 * axis;
  endfunction

  function automatic int unsigned dir_neg_bit(input int unsigned axis);
    return 2 * axis + 1;
  endfunction
endpackage

// File: rtl/wake_rate_gen.sv
module wake_rate_gen
  import wake_pkg::*;
#(
  parameter int unsigned FAST_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  output logic              tick_o
);
  localparam int unsigned MAX_PER = FAST_DIV << RATE_MAX;
  localparam int unsigned CNT_W   = $clog2(MAX_PER + 1);

  logic [CNT_W-1:0] div_q, div_d, period_m1;
  int unsigned      period;

  always_comb begin
    period    = FAST_DIV << (RATE_MAX - int'(rate_sel_i));
    period_m1 = CNT_W'(period - 1);
  end

  assign tick_o = en_i && (div_q >= period_m1);

  always_comb begin
    if (!en_i || tick_o) div_d = '0;
    else                 div_d = div_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/wake_dir_cmp.sv
module wake_dir_cmp
  import wake_pkg::*;
#(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned THR_W = 8
) (
  input  logic [NUM_AXES*SMP_W-1:0] axes_i,
  input  logic [THR_W-1:0]          thr_i,
  output dir_vec_t                  qual_o
);
  localparam int unsigned CMP_W = ((SMP_W > THR_W) ? SMP_W : THR_W) + 2;

  logic signed [CMP_W-1:0] pos_lim, neg_lim;

  always_comb begin
    pos_lim = $signed({{(CMP_W-THR_W){1'b0}}, thr_i});
    neg_lim = -pos_lim;
  end

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    logic signed [SMP_W-1:0] raw;
    logic signed [CMP_W-1:0] ext;
    assign raw = $signed(axes_i[a*SMP_W +: SMP_W]);
    assign ext = CMP_W'(raw);
    assign qual_o[dir_pos_bit(a)] = ext > pos_lim;
    assign qual_o[dir_neg_bit(a)] = ext < neg_lim;
  end
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce
  import wake_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  dir_vec_t         qual_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             release_i,
  output logic             wake_o,
  output dir_vec_t         dir_o
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             wake_q, wake_d;
  dir_vec_t         dir_q, dir_d;
  logic [DLY_W:0]   eff_dly, cnt_inc;
  logic             hit, reach;

  always_comb begin
    eff_dly = (delay_i == '0) ? (DLY_W+1)'(1) : {1'b0, delay_i};
    cnt_inc = {1'b0, cnt_q} + (DLY_W+1)'(1);
    hit     = |qual_i;
    reach   = cnt_inc >= eff_dly;
  end

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    wake_d  = 1'b0;
    dir_d   = dir_q;
    if (release_i) begin
      armed_d = 1'b1;
      dir_d   = '0;
      cnt_d   = '0;
    end else if (!en_i) begin
      cnt_d = '0;
    end else if (tick_i && armed_q) begin
      if (!hit) begin
        cnt_d = '0;
      end else if (reach) begin
        wake_d  = 1'b1;
        dir_d   = qual_i;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_inc[DLY_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      wake_q  <= 1'b0;
      dir_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      wake_q  <= wake_d;
      dir_q   <= dir_d;
    end
  end

  assign wake_o = wake_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/motion_wake_det.sv
module motion_wake_det
  import wake_pkg::*;
#(
  parameter int unsigned FAST_DIV = 4,
  parameter int unsigned SMP_W    = 8,
  parameter int unsigned THR_W    = 8,
  parameter int unsigned DLY_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable_i,
  input  logic [RATE_W-1:0]      rate_sel_i,
  input  logic [THR_W-1:0]       thr_i,
  input  logic [DLY_W-1:0]       delay_i,
  input  logic [NUM_DIRS-1:0]    dir_en_i,
  input  logic                   smp_valid_i,
  input  logic [SMP_W-1:0]       smp_x_i,
  input  logic [SMP_W-1:0]       smp_y_i,
  input  logic [SMP_W-1:0]       smp_z_i,
  input  logic                   release_i,
  output logic                   wake_o,
  output logic [NUM_DIRS-1:0]    wake_dir_o
);
  logic [NUM_AXES*SMP_W-1:0] hold_q, hold_d;
  logic                      tick;
  dir_vec_t                  qual, qual_en, dir_vec;

  // capture register, loaded only on the sample strobe (axis 0 = Z)
  always_comb begin
    hold_d = hold_q;
    if (smp_valid_i) hold_d = {smp_x_i, smp_y_i, smp_z_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  wake_rate_gen #(.FAST_DIV(FAST_DIV)) i_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (enable_i),
    .rate_sel_i(rate_sel_i),
    .tick_o    (tick)
  );

  wake_dir_cmp #(.SMP_W(SMP_W), .THR_W(THR_W)) i_cmp (
    .axes_i(hold_q),
    .thr_i (thr_i),
    .qual_o(qual)
  );

  assign qual_en = qual & dir_en_i;

  wake_debounce #(.DLY_W(DLY_W)) i_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (enable_i),
    .tick_i   (tick),
    .qual_i   (qual_en),
    .delay_i  (delay_i),
    .release_i(release_i),
    .wake_o   (wake_o),
    .dir_o    (dir_vec)
  );

  assign wake_dir_o = dir_vec;
endmodule

// File: rtl/wake_det_chk.sv
module wake_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable_i,
  input logic [5:0] dir_en_i,
  input logic       release_i,
  input logic       wake_o,
  input logic [5:0] wake_dir_o
);
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  assert_dir_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (wake_dir_o != 6'b0));

  assert_dir_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ((wake_dir_o & ~$past(dir_en_i)) == 6'b0));

  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !release_i |=> (wake_o || $stable(wake_dir_o)));

  assert_release_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> (wake_dir_o == 6'b0 && !wake_o));

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !wake_o);
endmodule

bind motion_wake_det wake_det_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable_i  (enable_i),
  .dir_en_i  (dir_en_i),
  .release_i (release_i),
  .wake_o    (wake_o),
  .wake_dir_o(wake_dir_o)
);

// File: tb/test_motion_wake_det.sv
module test_motion_wake_det;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable_i, smp_valid_i, release_i;
  logic [2:0] rate_sel_i;
  logic [7:0] thr_i, delay_i, smp_x_i, smp_y_i, smp_z_i;
  logic [5:0] dir_en_i;
  logic       wake_o;
  logic [5:0] wake_dir_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  motion_wake_det i_motion_wake_det (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .rate_sel_i(rate_sel_i),
    .thr_i(thr_i), .delay_i(delay_i), .dir_en_i(dir_en_i),
    .smp_valid_i(smp_valid_i), .smp_x_i(smp_x_i), .smp_y_i(smp_y_i),
    .smp_z_i(smp_z_i), .release_i(release_i),
    .wake_o(wake_o), .wake_dir_o(wake_dir_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // disable, release, load config and one captured sample
  task automatic prep(input logic [2:0] rate, input logic [7:0] thr, input logic [7:0] dly,
                      input logic [5:0] den, input logic [7:0] x, input logic [7:0] y,
                      input logic [7:0] z);
    @(negedge clk);
    enable_i = 0; release_i = 1;
    rate_sel_i = rate; thr_i = thr; delay_i = dly; dir_en_i = den;
    smp_x_i = x; smp_y_i = y; smp_z_i = z; smp_valid_i = 1;
    @(negedge clk);
    release_i = 0; smp_valid_i = 0;
  endtask

  // raise enable at this negedge; returns clock edges until wake_o seen, or -1
  task automatic start_wait(input int limit, output int n);
    enable_i = 1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wake_o) begin n = i; return; end
    end
    n = -1;
  endtask

  task automatic t_reset;
    check(wake_o == 0, "R1 wake_o", wake_o, 0);
    check(wake_dir_o == 0, "R1 wake_dir_o", wake_dir_o, 0);
  endtask

  task automatic t_positive;
    int n;
    prep(3'd7, 8'd8, 8'd3, 6'h3F, 8'sd9, 8'sd0, 8'sd0);
    start_wait(100, n);
    check(n == 12, "R5 R7 X+ fires on third tick", n, 12);
    check(wake_dir_o == 6'b010000, "R8 X+ direction", wake_dir_o, 6'b010000);
    @(negedge clk);
    check(wake_o == 0, "R8 single pulse", wake_o, 0);
    check(wake_dir_o == 6'b010000, "R9 direction held", wake_dir_o, 6'b010000);
  endtask

  task automatic t_equal;
    int n;
    prep(3'd7, 8'd8, 8'd1, 6'h3F, 8'sd8, -8'sd8, 8'sd0);
    start_wait(60, n);
    check(n == -1, "R2 R3 equal to threshold no event", n, -1);
  endtask

  task automatic t_negative;
    int n;
    prep(3'd7, 8'd8, 8'd1, 6'h3F, 8'sd0, 8'sd0, -8'sd9);
    start_wait(40, n);
    check(n == 4, "R3 Z- fires", n, 4);
    check(wake_dir_o == 6'b000010, "R3 Z- direction", wake_dir_o, 6'b000010);
    prep(3'd7, 8'd10, 8'd1, 6'h3F, 8'sd20, -8'sd20, 8'sd5);
    start_wait(40, n);
    check(wake_dir_o == 6'b011000, "R8 X+ and Y- reported together", wake_dir_o, 6'b011000);
  endtask

  task automatic t_mask;
    int n;
    prep(3'd7, 8'd8, 8'd1, 6'b101111, 8'sd20, 8'sd0, 8'sd0);
    start_wait(60, n);
    check(n == -1, "R4 disabled X+ no event", n, -1);
    check(wake_dir_o == 0, "R4 nothing reported", wake_dir_o, 0);
    prep(3'd7, 8'd8, 8'd1, 6'b101111, 8'sd20, 8'sd20, 8'sd0);
    start_wait(40, n);
    check(wake_dir_o == 6'b000100, "R4 only Y+ reported", wake_dir_o, 6'b000100);
  endtask

  task automatic t_zero_delay;
    int n;
    prep(3'd7, 8'd8, 8'd0, 6'h3F, 8'sd0, 8'sd30, 8'sd0);
    start_wait(40, n);
    check(n == 4, "R5 delay 0 acts as 1", n, 4);
  endtask

  task automatic t_rates;
    int n;
    prep(3'd5, 8'd8, 8'd2, 6'h3F, 8'sd0, 8'sd0, 8'sd40);
    start_wait(100, n);
    check(n == 32, "R7 code 5 period 16", n, 32);
    prep(3'd0, 8'd8, 8'd1, 6'h3F, 8'sd0, 8'sd0, 8'sd40);
    start_wait(700, n);
    check(n == 512, "R7 code 0 period 512", n, 512);
  endtask

  task automatic t_restart;
    int n = -1;
    prep(3'd7, 8'd8, 8'd3, 6'h3F, 8'sd30, 8'sd0, 8'sd0);
    enable_i = 1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (wake_o && n < 0) n = i;
      smp_valid_i = 0;
      if (i == 9)  begin smp_x_i = 8'sd0;  smp_valid_i = 1; end
      if (i == 13) begin smp_x_i = 8'sd30; smp_valid_i = 1; end
    end
    check(n == 24, "R6 quiet tick restarts count", n, 24);
  endtask

  task automatic t_release;
    int n;
    bit seen = 0;
    prep(3'd7, 8'd8, 8'd1, 6'h3F, -8'sd50, 8'sd0, 8'sd0);
    start_wait(40, n);
    check(wake_dir_o == 6'b100000, "R8 X- direction", wake_dir_o, 6'b100000);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (wake_o) seen = 1;
    end
    check(!seen, "R9 no event before release", seen, 0);
    check(wake_dir_o == 6'b100000, "R9 held until release", wake_dir_o, 6'b100000);
    release_i = 1;
    @(negedge clk);
    release_i = 0;
    check(wake_dir_o == 0, "R9 release clears direction", wake_dir_o, 0);
    start_wait(40, n);
    check(n != -1, "R9 re-armed after release", n, 1);
  endtask

  task automatic t_disable;
    int n;
    bit seen = 0;
    prep(3'd7, 8'd8, 8'd3, 6'h3F, 8'sd0, 8'sd0, 8'sd60);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (wake_o) seen = 1;
    end
    check(!seen, "R10 disabled no event", seen, 0);
    enable_i = 1;
    repeat (9) @(negedge clk);
    enable_i = 0;
    @(negedge clk);
    start_wait(60, n);
    check(n == 12, "R10 count cleared while disabled", n, 12);
  endtask

  task automatic t_strobe;
    int n;
    prep(3'd7, 8'd8, 8'd1, 6'h3F, 8'sd0, 8'sd0, 8'sd0);
    smp_x_i = 8'sd50;
    start_wait(40, n);
    check(n == -1, "R11 input without strobe ignored", n, -1);
    check(wake_dir_o == 0, "R11 nothing reported", wake_dir_o, 0);
  endtask

  initial begin
    rst_n = 0; enable_i = 0; smp_valid_i = 0; release_i = 0;
    rate_sel_i = 0; thr_i = 8'd8; delay_i = 8'd1; dir_en_i = 6'h3F;
    smp_x_i = 0; smp_y_i = 0; smp_z_i = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_positive();
    t_equal();
    t_negative();
    t_mask();
    t_zero_delay();
    t_rates();
    t_restart();
    t_release();
    t_disable();
    t_strobe();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule